// File: doc/BRIEF.md
# Timestamp-Gated Transmit Sample Release

This block sits between the transmit command parser and the converter path. The parser writes transmit samples into a queue, each paired with a timestamp. The parser works on the bus clock. The queue is a dual-clock FIFO, so the samples cross into the converter sample clock domain.

On the sample side, a counter advances once per sample clock and serves as the time base. Software can load the counter, for example with zero at the start of a TDMA epoch. When timed mode is on and the converter is ready, the block compares the head sample's timestamp with the counter on every cycle:

- A sample whose time has come goes out.
- A sample whose time has not come waits.
- A sample whose time has already passed is discarded.

Whenever no real sample goes out in a timed cycle, the block drives zero onto the stream. Two sticky flags record late samples and underruns. The packet builder reads them into its status header, and reading them clears them.

Top module: `tx_time_gate`

## Requirements
- R1: `timeNow` is 0 in reset and increases by 1 (modulo 2^TIME_W) on every `smpClk` edge. In a cycle where `timeLoad` is high, the next value is `timeLoadVal` instead.
- R2: A "live" cycle is one where `timedEn` and `dacReady` are both high. In a live cycle, if the queue head timestamp equals `timeNow`, the head is removed. On the next edge, `outValid` goes high and `outSample` carries that sample.
- R3: Let d = head timestamp − `timeNow` modulo 2^TIME_W. In a live cycle where d is nonzero and its top bit is clear, the head stays queued, `outValid` goes high and `outSample` is 0.
- R4: In a live cycle where the top bit of d is set, the head is removed without being sent. `outSample` is 0 with `outValid` high, and `lateFlag` is set.
- R5: In a live cycle with an empty queue, `outSample` is 0 with `outValid` high, and `underFlag` is set.
- R6: `lateFlag` and `underFlag` are 0 in reset and stay set until a cycle with `flagRead` high. The cycle after that, each flag is cleared, unless it was set again in that same cycle; in that case it stays 1.
- R7: The time comparison follows R3/R4 across the counter wrap from all ones to zero, so samples timed just after the wrap release at their own counts and are not marked late.
- R8: In a cycle that is not live, `outValid` is 0 on the next edge, nothing leaves the queue, and neither flag is set.
- R9: A write with `wrValid` high and `wrFull` low is queued. `wrFull` is high while 2^ADDR_W entries are held. A write while `wrFull` is high is ignored.
- R10: Samples leave the queue in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Bus-side clock for queue writes |
| wrRstN | input | 1 | Active-low reset, write side |
| wrValid | input | 1 | Write strobe for one timestamped sample |
| wrSample | input | SAMPLE_W | Sample value to queue |
| wrTime | input | TIME_W | Release timestamp of the sample |
| wrFull | output | 1 | Queue cannot accept a write |
| smpClk | input | 1 | Converter sample clock |
| smpRstN | input | 1 | Active-low reset, sample side |
| timedEn | input | 1 | Timed release mode enable |
| dacReady | input | 1 | Converter accepts a sample this cycle |
| timeLoad | input | 1 | Load strobe for the time base |
| timeLoadVal | input | TIME_W | Value loaded into the time base |
| flagRead | input | 1 | Packet builder reads and clears the flags |
| timeNow | output | TIME_W | Current time base value |
| outValid | output | 1 | Output sample slot is valid |
| outSample | output | SAMPLE_W | Released sample, or zero fill |
| lateFlag | output | 1 | Sticky: a head sample was discarded as late |
| underFlag | output | 1 | Sticky: queue was empty in a timed cycle |

## Verification
The bench builds the block with SAMPLE_W=8, TIME_W=32, ADDR_W=2 and SYNC_STAGES=2. The four-entry queue makes the full condition and the ignored overflow write reachable after a handful of writes. Keeping the full 32-bit time base lets the counter be loaded just below its wrap point, so releases that straddle the rollover are tested.

The bench sweeps single-sample timestamps from three counts in the past to five in the future, each under a shifting ready pattern. It predicts every output slot from a queue model that applies the signed-difference rule.

// File: rtl/tgate_pkg.sv
package tgate_pkg;

  // Per-cycle decisions passed from the release control to the datapath.
  typedef struct packed {
    logic fire;       // a live slot: the output register takes a value
    logic pop;        // remove the queue head
    logic takeHead;   // the slot carries the head sample instead of zero
    logic markLate;   // set the sticky late flag
    logic markUnder;  // set the sticky underrun flag
  } gateStrobe_t;

endpackage

// File: rtl/tgate_sync.sv
module tgate_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/tgate_fifo.sv
module tgate_fifo #(
  parameter int DATA_W      = 48,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [PW-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PW-1:0] rdGraySync, wrGraySync;
  logic [PW-1:0] wrBinNext, rdBinNext;

  // Write side
  assign wrFull    = (wrGray == {~rdGraySync[PW-1:PW-2], rdGraySync[PW-3:0]});
  assign wrBinNext = wrBin + PW'(1);

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrEn && !wrFull) begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrEn && !wrFull) mem[wrBin[ADDR_W-1:0]] <= wrData;
  end

  tgate_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk(wrClk), .rstN(wrRstN), .din(rdGray), .dout(rdGraySync)
  );

  // Read side: the head entry is visible without a read request
  assign rdEmpty   = (rdGray == wrGraySync);
  assign rdData    = mem[rdBin[ADDR_W-1:0]];
  assign rdBinNext = rdBin + PW'(1);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdEn && !rdEmpty) begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  tgate_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk(rdClk), .rstN(rdRstN), .din(wrGray), .dout(wrGraySync)
  );
endmodule

// File: rtl/tgate_ctrl.sv
module tgate_ctrl
  import tgate_pkg::*;
#(
  parameter int TIME_W = 32
) (
  input  logic              timedEn,
  input  logic              dacReady,
  input  logic              headEmpty,
  input  logic [TIME_W-1:0] headTime,
  input  logic [TIME_W-1:0] timeNow,
  output gateStrobe_t       st
);
  logic [TIME_W-1:0] delta;
  logic live, onTime, passed;

  // Modulo difference: the top bit marks a timestamp in the past
  assign delta  = headTime - timeNow;
  assign live   = timedEn && dacReady;
  assign onTime = (delta == '0);
  assign passed = delta[TIME_W-1];

  always_comb begin
    st           = '0;
    st.fire      = live;
    st.markUnder = live && headEmpty;
    st.takeHead  = live && !headEmpty && onTime;
    st.markLate  = live && !headEmpty && passed;
    st.pop       = st.takeHead || st.markLate;
  end
endmodule

// File: rtl/tgate_datapath.sv
module tgate_datapath
  import tgate_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int TIME_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  gateStrobe_t         st,
  input  logic [SAMPLE_W-1:0] headSample,
  input  logic                timeLoad,
  input  logic [TIME_W-1:0]   timeLoadVal,
  input  logic                flagRead,
  output logic [TIME_W-1:0]   timeNow,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample,
  output logic                lateFlag,
  output logic                underFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeNow <= '0;
    else if (timeLoad) timeNow <= timeLoadVal;
    else timeNow <= timeNow + TIME_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      outValid <= st.fire;
      if (st.fire) outSample <= st.takeHead ? headSample : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lateFlag  <= 1'b0;
      underFlag <= 1'b0;
    end else begin
      lateFlag  <= st.markLate  || (lateFlag  && !flagRead);
      underFlag <= st.markUnder || (underFlag && !flagRead);
    end
  end
endmodule

// File: rtl/tx_time_gate.sv
module tx_time_gate
  import tgate_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int TIME_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                wrClk,
  input  logic                wrRstN,
  input  logic                wrValid,
  input  logic [SAMPLE_W-1:0] wrSample,
  input  logic [TIME_W-1:0]   wrTime,
  output logic                wrFull,
  input  logic                smpClk,
  input  logic                smpRstN,
  input  logic                timedEn,
  input  logic                dacReady,
  input  logic                timeLoad,
  input  logic [TIME_W-1:0]   timeLoadVal,
  input  logic                flagRead,
  output logic [TIME_W-1:0]   timeNow,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample,
  output logic                lateFlag,
  output logic                underFlag
);
  localparam int WORD_W = TIME_W + SAMPLE_W;

  logic [WORD_W-1:0] headWord;
  logic              headEmpty;
  gateStrobe_t       st;

  tgate_fifo #(.DATA_W(WORD_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_queue (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrValid), .wrData({wrTime, wrSample}),
    .wrFull(wrFull), .rdClk(smpClk), .rdRstN(smpRstN), .rdEn(st.pop),
    .rdData(headWord), .rdEmpty(headEmpty)
  );

  tgate_ctrl #(.TIME_W(TIME_W)) u_ctrl (
    .timedEn(timedEn), .dacReady(dacReady), .headEmpty(headEmpty),
    .headTime(headWord[WORD_W-1:SAMPLE_W]), .timeNow(timeNow), .st(st)
  );

  tgate_datapath #(.SAMPLE_W(SAMPLE_W), .TIME_W(TIME_W)) u_path (
    .clk(smpClk), .rstN(smpRstN), .st(st), .headSample(headWord[SAMPLE_W-1:0]),
    .timeLoad(timeLoad), .timeLoadVal(timeLoadVal), .flagRead(flagRead),
    .timeNow(timeNow), .outValid(outValid), .outSample(outSample),
    .lateFlag(lateFlag), .underFlag(underFlag)
  );
endmodule

// File: rtl/tgate_chk.sv
module tgate_chk #(
  parameter int SAMPLE_W = 16,
  parameter int TIME_W   = 32
) (
  input logic                smpClk,
  input logic                smpRstN,
  input logic                timedEn,
  input logic                dacReady,
  input logic                timeLoad,
  input logic [TIME_W-1:0]   timeLoadVal,
  input logic                flagRead,
  input logic                headEmpty,
  input logic [TIME_W-1:0]   timeNow,
  input logic                outValid,
  input logic [SAMPLE_W-1:0] outSample,
  input logic                lateFlag,
  input logic                underFlag
);
  // R1
  time_step_chk: assert property (@(posedge smpClk) disable iff (!smpRstN)
    !timeLoad |=> timeNow == TIME_W'($past(timeNow) + 1));

  // R1
  time_load_chk: assert property (@(posedge smpClk) disable iff (!smpRstN)
    timeLoad |=> timeNow == $past(timeLoadVal));

  // R8
  idle_quiet_chk: assert property (@(posedge smpClk) disable iff (!smpRstN)
    !(timedEn && dacReady) |=> !outValid);

  // R6
  late_hold_chk: assert property (@(posedge smpClk) disable iff (!smpRstN)
    lateFlag && !flagRead |=> lateFlag);

  // R6
  under_hold_chk: assert property (@(posedge smpClk) disable iff (!smpRstN)
    underFlag && !flagRead |=> underFlag);

  // R5
  under_cause_chk: assert property (@(posedge smpClk) disable iff (!smpRstN)
    !underFlag |=> !underFlag || $past(timedEn && dacReady && headEmpty));

  // R4
  late_cause_chk: assert property (@(posedge smpClk) disable iff (!smpRstN)
    !lateFlag |=> !lateFlag || $past(timedEn && dacReady && !headEmpty));

  // R2
  sample_src_chk: assert property (@(posedge smpClk) disable iff (!smpRstN)
    outValid && (outSample != '0) |-> $past(!headEmpty));
endmodule

bind tx_time_gate tgate_chk #(.SAMPLE_W(SAMPLE_W), .TIME_W(TIME_W)) u_chk (
  .smpClk(smpClk), .smpRstN(smpRstN), .timedEn(timedEn), .dacReady(dacReady),
  .timeLoad(timeLoad), .timeLoadVal(timeLoadVal), .flagRead(flagRead),
  .headEmpty(headEmpty), .timeNow(timeNow), .outValid(outValid),
  .outSample(outSample), .lateFlag(lateFlag), .underFlag(underFlag)
);

// File: tb/tx_time_gate_bench.sv
`timescale 1ns/1ps
module tx_time_gate_bench;
  localparam int SW = 8;
  localparam int TW = 32;

  logic wrClk = 0, smpClk = 0;
  logic wrRstN = 0, smpRstN = 0;
  logic wrValid = 0;
  logic [SW-1:0] wrSample = '0;
  logic [TW-1:0] wrTime = '0;
  logic wrFull;
  logic timedEn = 0, dacReady = 0, timeLoad = 0, flagRead = 0;
  logic [TW-1:0] timeLoadVal = '0;
  logic [TW-1:0] timeNow;
  logic outValid, lateFlag, underFlag;
  logic [SW-1:0] outSample;

  always #10 smpClk = ~smpClk;   // 50 MHz
  always #7  wrClk  = ~wrClk;

  tx_time_gate #(.SAMPLE_W(SW), .TIME_W(TW), .ADDR_W(2), .SYNC_STAGES(2)) u_tx_time_gate (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrSample(wrSample),
    .wrTime(wrTime), .wrFull(wrFull), .smpClk(smpClk), .smpRstN(smpRstN),
    .timedEn(timedEn), .dacReady(dacReady), .timeLoad(timeLoad),
    .timeLoadVal(timeLoadVal), .flagRead(flagRead), .timeNow(timeNow),
    .outValid(outValid), .outSample(outSample), .lateFlag(lateFlag),
    .underFlag(underFlag)
  );

  int nChecks = 0, nFails = 0;

  // Bench queue model
  logic [TW-1:0] qTs [16];
  logic [SW-1:0] qSm [16];
  int qHead = 0, qCnt = 0;
  logic [TW-1:0] mTime = '0;
  bit mLate = 0, mUnder = 0;
  bit wrapPhase = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [TW-1:0] ts, input logic [SW-1:0] sm);
    bit acc;
    @(negedge wrClk);
    acc = !wrFull;
    wrValid = 1; wrTime = ts; wrSample = sm;
    @(posedge wrClk);
    @(negedge wrClk);
    wrValid = 0;
    if (acc) begin
      qTs[(qHead + qCnt) % 16] = ts;
      qSm[(qHead + qCnt) % 16] = sm;
      qCnt++;
    end
  endtask

  // One sample-clock cycle; called at a falling edge of smpClk
  task automatic step(input bit te, input bit rdy, input bit ld,
                      input logic [TW-1:0] lv, input bit fr);
    bit expV, sL, sU;
    logic [SW-1:0] expS;
    logic [TW-1:0] d;
    string tg;
    timedEn = te; dacReady = rdy; timeLoad = ld; timeLoadVal = lv; flagRead = fr;
    expV = 0; expS = '0; sL = 0; sU = 0; tg = "R8";
    if (te && rdy) begin
      expV = 1;
      if (qCnt == 0) begin
        sU = 1; tg = "R5";
      end else begin
        d = qTs[qHead] - mTime;
        if (d == '0) begin
          expS = qSm[qHead]; qHead = (qHead + 1) % 16; qCnt--; tg = "R2 R10";
        end else if (d[TW-1]) begin
          sL = 1; qHead = (qHead + 1) % 16; qCnt--; tg = "R4";
        end else tg = "R3";
      end
      if (wrapPhase) tg = {tg, " R7"};
    end
    mLate  = sL || (mLate  && !fr);
    mUnder = sU || (mUnder && !fr);
    mTime  = ld ? lv : mTime + 1;
    @(posedge smpClk);
    @(negedge smpClk);
    chk(outValid == expV, tg, "outValid", 32'(outValid), 32'(expV));
    if (expV) chk(outSample == expS, tg, "outSample", 32'(outSample), 32'(expS));
    chk(lateFlag == mLate, sL ? "R4" : "R6", "lateFlag", 32'(lateFlag), 32'(mLate));
    chk(underFlag == mUnder, sU ? "R5" : "R6", "underFlag", 32'(underFlag), 32'(mUnder));
    chk(timeNow == mTime, "R1", "timeNow", timeNow, mTime);
    timeLoad = 0; flagRead = 0; timedEn = 0;
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge smpClk);
    chk(timeNow == '0, "R1", "timeNow in reset", timeNow, 0);
    chk(!outValid, "R8", "outValid in reset", 32'(outValid), 0);
    chk(!lateFlag && !underFlag, "R6", "flags in reset", {lateFlag, underFlag}, 0);
    chk(!wrFull, "R9", "wrFull in reset", 32'(wrFull), 0);
    @(negedge wrClk); wrRstN = 1;
    @(negedge smpClk); smpRstN = 1;

    // Fill to full, then an ignored fifth write
    push(102, 8'h11); push(104, 8'h22); push(104, 8'h33);
    chk(!wrFull, "R9", "wrFull at 3 entries", 32'(wrFull), 0);
    push(109, 8'h44);
    chk(wrFull, "R9", "wrFull at 4 entries", 32'(wrFull), 1);
    push(110, 8'h55);
    chk(qCnt == 4, "R9", "model entries", qCnt, 4);
    repeat (6) @(negedge smpClk);
    step(0, 1, 1, 100, 1);
    repeat (14) step(1, 1, 0, 0, 0);
    step(1, 1, 0, 0, 1);  // set and read in the same cycle: set wins
    step(0, 1, 0, 0, 1);  // read clears both
    step(0, 1, 0, 0, 0);
    repeat (8) @(negedge wrClk);
    chk(!wrFull, "R9", "wrFull after drain", 32'(wrFull), 0);

    // Stall across a release time
    push(50, 8'hA1); push(52, 8'hA2);
    repeat (6) @(negedge smpClk);
    step(0, 1, 1, 48, 1);
    step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0); step(1, 1, 0, 0, 0);

    // Counter rollover
    push(32'hFFFF_FFFF, 8'hB1); push(32'h0000_0001, 8'hB2); push(32'h0000_0002, 8'hB3);
    repeat (6) @(negedge smpClk);
    step(0, 1, 1, 32'hFFFF_FFFD, 1);
    wrapPhase = 1;
    repeat (7) step(1, 1, 0, 0, 0);
    wrapPhase = 0;
    chk(!lateFlag, "R7", "no late across wrap", 32'(lateFlag), 0);

    // Sweep of timestamp offsets under a shifting ready pattern
    for (int off = -3; off <= 5; off++) begin
      push(32'(1000 + off), 8'(8'h43 + off));
      repeat (6) @(negedge smpClk);
      step(0, 1, 1, 1000, 1);
      for (int i = 0; i < 9; i++) step(1, ((i + off + 3) % 4) != 1, 0, 0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule